// File: doc/BRIEF.md
# Host Request Mailbox

This block is a byte-wide mailbox between a host register port and an embedded acquisition processor. The host sets a buffer pointer through an address register. It streams a request into a small buffer through a data register and then hands the buffer over by setting a request flag in a status register. The processor side sees the flag as `req_pending`. It reads the request and writes its response at random addresses, then pulses `proc_done` to return the buffer. The host polls the status register until the flag drops, reloads the pointer and reads the response back through the same data register.

A request starts with a command byte and a message-tag byte, followed by the payload. A response also starts with two header bytes, followed by its data. The mailbox does not interpret any of these bytes. Ownership is exclusive. While the flag is set, only the processor may write the buffer. While it is clear, only the host may write it.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset `req_pending` is 0, `host_rdata` is 0x00, the buffer pointer is 0 and every buffer byte is 0x00.
- R2: A host write to offset 0xA6 loads the buffer pointer with the written value modulo 64 (its low six bits). A host read of 0xA6 returns the pointer, zero-extended.
- R3: When the request flag is clear, a host write to offset 0xA7 stores the byte at the pointer and advances the pointer by one, wrapping from 63 to 0.
- R4: A host read of offset 0xA7 places the byte at the pointer on `host_rdata` after the next clock edge and advances the pointer by one, wrapping from 63 to 0. `host_rdata` holds its value until the next read.
- R5: A host write to the status register at offset 0xA8 changes the request flag (bit 0) only when the load-enable bit (bit 1) of the same byte is 1. The flag then takes the value of bit 0. With bit 1 at 0 the write has no effect.
- R6: A host read of 0xA8 returns the request flag in bit 0 and zeros in all other bits, with no side effect on the flag or the pointer. A read of any unmapped offset returns 0x00.
- R7: While the request flag is set, host writes to 0xA7 are ignored: no byte is stored and the pointer does not move.
- R8: `req_pending` shows the request flag. A processor write (`proc_wr_en`) stores `proc_wdata` at `proc_addr` only while the flag is set, and is ignored otherwise.
- R9: A `proc_done` pulse while the flag is set clears it at the next edge. A host status write with load-enable in the same cycle takes priority and sets the flag to its bit 0.
- R10: `proc_rdata` shows, without a clock delay, the buffer byte at `proc_addr`.
- R11: A full exchange round-trips. The host loads a command, a tag and a payload from address 0, then sets the flag. The processor answers and pulses done. The host then polls the flag clear and reads the response from address 0, and it matches byte for byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe, ignored when host_wr_en is high |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| req_pending | output | 1 | Request flag, buffer owned by the processor |
| proc_wr_en | input | 1 | Processor buffer write strobe |
| proc_addr | input | 6 | Processor buffer address |
| proc_wdata | input | 8 | Processor write byte |
| proc_done | input | 1 | One-cycle completion pulse |
| proc_rdata | output | 8 | Buffer byte at proc_addr |

## Verification
The bench goes after pointer wrap at byte 63 on both writes and reads. A design with an off-by-one wrap would store or return the byte at 64 and scramble the response tail. It sets and clears the flag with status bytes that lack the load-enable bit, which a design that ignores that bit would obey. It also lands a done pulse in the same cycle as a host re-arm, where a design with the wrong priority would drop a fresh request. It issues data writes while the processor owns the buffer, which a leaky design would let corrupt the request or shift the pointer. Processor writes while the host owns the buffer must likewise leave the bytes untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Host register selected by the current offset
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PTR  = 2'd1,
      SEL_DATA = 2'd2,
      SEL_STAT = 2'd3
   } mbx_sel_e;

   // True when n is a power of two
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
   import mbx_pkg::*;
#(
   parameter int             AW       = 8,
   parameter logic [AW-1:0]  PTR_OFS  = AW'(8'hA6),
   parameter logic [AW-1:0]  DATA_OFS = AW'(8'hA7),
   parameter logic [AW-1:0]  STAT_OFS = AW'(8'hA8)
) (
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   output mbx_sel_e      sel,
   output logic          wr_ptr,
   output logic          wr_data,
   output logic          wr_stat,
   output logic          rd_any,
   output logic          rd_data
);

   always_comb begin
      if (addr == PTR_OFS)       sel = SEL_PTR;
      else if (addr == DATA_OFS) sel = SEL_DATA;
      else if (addr == STAT_OFS) sel = SEL_STAT;
      else                       sel = SEL_NONE;
   end

   // A write in the same cycle suppresses the read
   assign rd_any  = rd_en && !wr_en;
   assign wr_ptr  = wr_en && (sel == SEL_PTR);
   assign wr_data = wr_en && (sel == SEL_DATA);
   assign wr_stat = wr_en && (sel == SEL_STAT);
   assign rd_data = rd_any && (sel == SEL_DATA);

endmodule

// File: rtl/mbx_ptr.sv
module mbx_ptr
   import mbx_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          step,
   output logic [PW-1:0] ptr
);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] ptr_inc;
   logic [PW-1:0] ptr_ld;

   // Loaded value is reduced modulo the buffer depth
   assign ptr_ld = PW'(32'(load_val) % DEPTH);

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_free
         assign ptr_inc = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_inc = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= ptr_ld;
      else if (step) ptr_q <= ptr_inc;
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/mbx_req_flag.sv
module mbx_req_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stat,
   input  logic set_val,
   input  logic load_en,
   input  logic done,
   output logic req
);

   logic req_q;

   // Host load-enabled write outranks the completion pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  req_q <= 1'b0;
      else if (wr_stat && load_en) req_q <= set_val;
      else if (done)               req_q <= 1'b0;
   end

   assign req = req_q;

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_we,
   input  logic [PW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   input  logic          p_we,
   input  logic [PW-1:0] p_addr,
   input  logic [DW-1:0] p_wdata,
   output logic [DW-1:0] h_rdata,
   output logic [DW-1:0] p_rdata
);

   logic [DEPTH-1:0][DW-1:0] cells;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_cell
         logic          hit_h;
         logic          hit_p;
         logic [DW-1:0] cell_q;

         assign hit_h = h_we && (h_addr == PW'(e));
         assign hit_p = p_we && (p_addr == PW'(e));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cell_q <= '0;
            else if (hit_h) cell_q <= h_wdata;
            else if (hit_p) cell_q <= p_wdata;
         end

         assign cells[e] = cell_q;
      end
   endgenerate

   assign h_rdata = cells[h_addr];
   assign p_rdata = cells[p_addr];

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
   import mbx_pkg::*;
#(
   parameter int            AW       = 8,
   parameter int            DW       = 8,
   parameter int            DEPTH    = 64,
   parameter logic [AW-1:0] PTR_OFS  = AW'(8'hA6),
   parameter logic [AW-1:0] DATA_OFS = AW'(8'hA7),
   parameter logic [AW-1:0] STAT_OFS = AW'(8'hA8),
   parameter int            REQ_BIT  = 0,
   parameter int            LOAD_BIT = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     host_wr_en,
   input  logic                     host_rd_en,
   input  logic [AW-1:0]            host_addr,
   input  logic [DW-1:0]            host_wdata,
   output logic [DW-1:0]            host_rdata,
   output logic                     req_pending,
   input  logic                     proc_wr_en,
   input  logic [$clog2(DEPTH)-1:0] proc_addr,
   input  logic [DW-1:0]            proc_wdata,
   input  logic                     proc_done,
   output logic [DW-1:0]            proc_rdata
);

   localparam int PW = $clog2(DEPTH);

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || DEPTH > (1 << DW)) begin : g_bad_depth
         $error("mbx_mailbox: DEPTH must lie in 2..2**DW");
      end
      if (DW < 2 || DW > 16) begin : g_bad_dw
         $error("mbx_mailbox: DW must lie in 2..16");
      end
      if (REQ_BIT == LOAD_BIT || REQ_BIT >= DW || LOAD_BIT >= DW
          || REQ_BIT < 0 || LOAD_BIT < 0) begin : g_bad_bits
         $error("mbx_mailbox: status bit positions invalid");
      end
      if (PTR_OFS == DATA_OFS || PTR_OFS == STAT_OFS
          || DATA_OFS == STAT_OFS) begin : g_bad_ofs
         $error("mbx_mailbox: register offsets must differ");
      end
   endgenerate

   mbx_sel_e      sel;
   logic          wr_ptr, wr_data, wr_stat, rd_any, rd_data;
   logic          req;
   logic [PW-1:0] ptr_q;
   logic          host_store;
   logic          proc_store;
   logic          ptr_step;
   logic [DW-1:0] buf_rd;
   logic [DW-1:0] stat_rd;
   logic [DW-1:0] rd_next;
   logic [DW-1:0] rdata_q;

   mbx_host_decode #(
      .AW       (AW),
      .PTR_OFS  (PTR_OFS),
      .DATA_OFS (DATA_OFS),
      .STAT_OFS (STAT_OFS)
   ) u_decode (
      .wr_en   (host_wr_en),
      .rd_en   (host_rd_en),
      .addr    (host_addr),
      .sel     (sel),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_data),
      .wr_stat (wr_stat),
      .rd_any  (rd_any),
      .rd_data (rd_data)
   );

   // Buffer ownership follows the request flag
   assign host_store = wr_data && !req;
   assign proc_store = proc_wr_en && req;
   assign ptr_step   = host_store || rd_data;

   mbx_ptr #(
      .DEPTH (DEPTH),
      .DW    (DW)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ptr),
      .load_val (host_wdata),
      .step     (ptr_step),
      .ptr      (ptr_q)
   );

   mbx_req_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stat (wr_stat),
      .set_val (host_wdata[REQ_BIT]),
      .load_en (host_wdata[LOAD_BIT]),
      .done    (proc_done),
      .req     (req)
   );

   mbx_store #(
      .DEPTH (DEPTH),
      .DW    (DW)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .h_we    (host_store),
      .h_addr  (ptr_q),
      .h_wdata (host_wdata),
      .p_we    (proc_store),
      .p_addr  (proc_addr),
      .p_wdata (proc_wdata),
      .h_rdata (buf_rd),
      .p_rdata (proc_rdata)
   );

   always_comb begin
      stat_rd          = '0;
      stat_rd[REQ_BIT] = req;
   end

   always_comb begin
      case (sel)
         SEL_PTR:  rd_next = DW'(ptr_q);
         SEL_DATA: rd_next = buf_rd;
         SEL_STAT: rd_next = stat_rd;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_any) rdata_q <= rd_next;
   end

   assign host_rdata  = rdata_q;
   assign req_pending = req;

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
   parameter int            AW       = 8,
   parameter int            DW       = 8,
   parameter int            DEPTH    = 64,
   parameter logic [AW-1:0] DATA_OFS = AW'(8'hA7),
   parameter logic [AW-1:0] STAT_OFS = AW'(8'hA8),
   parameter int            REQ_BIT  = 0,
   parameter int            LOAD_BIT = 1,
   localparam int           PW       = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr_en,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_wdata,
   input logic          req_pending,
   input logic          proc_done,
   input logic [PW-1:0] buf_ptr
);

   logic stat_wr, stat_load, data_wr;
   assign stat_wr   = host_wr_en && (host_addr == STAT_OFS);
   assign stat_load = stat_wr && host_wdata[LOAD_BIT];
   assign data_wr   = host_wr_en && (host_addr == DATA_OFS);

   // R8
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_pending) |-> $past(stat_load && host_wdata[REQ_BIT]));

   // R9
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_pending && proc_done && !stat_load |=> !req_pending);

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_load |=> req_pending == $past(host_wdata[REQ_BIT]));

   // R5
   no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && !host_wdata[LOAD_BIT] && !proc_done |=> $stable(req_pending));

   // R7
   owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_pending && data_wr |=> $stable(buf_ptr));

   // R3
   data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_pending && data_wr && buf_ptr != PW'(DEPTH - 1)
      |=> buf_ptr == $past(buf_ptr) + 1'b1);

   // R3
   data_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_pending && data_wr && buf_ptr == PW'(DEPTH - 1) |=> buf_ptr == '0);

endmodule

bind mbx_mailbox mbx_mailbox_chk #(
   .AW       (AW),
   .DW       (DW),
   .DEPTH    (DEPTH),
   .DATA_OFS (DATA_OFS),
   .STAT_OFS (STAT_OFS),
   .REQ_BIT  (REQ_BIT),
   .LOAD_BIT (LOAD_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_wr_en  (host_wr_en),
   .host_addr   (host_addr),
   .host_wdata  (host_wdata),
   .req_pending (req_pending),
   .proc_done   (proc_done),
   .buf_ptr     (ptr_q)
);

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_mailbox_tb;

   localparam logic [7:0] A_PTR = 8'hA6, A_DAT = 8'hA7, A_STA = 8'hA8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       host_wr_en = 0, host_rd_en = 0;
   logic [7:0] host_addr = 0, host_wdata = 0, host_rdata;
   logic       req_pending;
   logic       proc_wr_en = 0, proc_done = 0;
   logic [5:0] proc_addr = 0;
   logic [7:0] proc_wdata = 0, proc_rdata;

   always #2 clk = ~clk;

   mbx_mailbox u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .req_pending(req_pending),
      .proc_wr_en(proc_wr_en), .proc_addr(proc_addr), .proc_wdata(proc_wdata),
      .proc_done(proc_done), .proc_rdata(proc_rdata)
   );

   // Behavioural reference model
   logic [7:0] m_buf [64];
   int         m_ptr;
   bit         m_req;
   logic [7:0] m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_buf[i]) m_buf[i] = 8'h00;
         m_ptr = 0; m_req = 0; m_rd = 8'h00;
      end else begin
         bit old_req, new_req;
         int new_ptr;
         old_req = m_req; new_req = m_req; new_ptr = m_ptr;
         if (host_wr_en) begin
            if (host_addr == A_PTR) new_ptr = host_wdata % 64;
            else if (host_addr == A_DAT && !old_req) begin
               m_buf[m_ptr] = host_wdata;
               new_ptr = (m_ptr + 1) % 64;
            end
         end else if (host_rd_en) begin
            if (host_addr == A_DAT) begin
               m_rd = m_buf[m_ptr];
               new_ptr = (m_ptr + 1) % 64;
            end else if (host_addr == A_PTR) m_rd = 8'(m_ptr);
            else if (host_addr == A_STA) m_rd = {7'd0, old_req};
            else m_rd = 8'h00;
         end
         if (proc_wr_en && old_req) m_buf[proc_addr] = proc_wdata;
         if (proc_done && old_req) new_req = 0;
         if (host_wr_en && host_addr == A_STA && host_wdata[1]) new_req = host_wdata[0];
         m_req = new_req; m_ptr = new_ptr;
      end
   end

   int    n_cmp = 0, n_bad = 0;
   bit    fin = 0;
   string phase = "R1 reset state";

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%02h expected=%02h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) if (!fin) begin
      chk("host_rdata", host_rdata, m_rd);
      chk("req_pending", {7'd0, req_pending}, {7'd0, m_req});
      chk("proc_rdata", proc_rdata, m_buf[proc_addr]);
   end

   task automatic hw(logic [7:0] a, logic [7:0] d);
      @(posedge clk); #1 host_wr_en = 1; host_addr = a; host_wdata = d;
      @(posedge clk); #1 host_wr_en = 0;
   endtask

   task automatic hr(logic [7:0] a, output logic [7:0] v);
      @(posedge clk); #1 host_rd_en = 1; host_addr = a;
      @(posedge clk); #1 host_rd_en = 0; v = host_rdata;
   endtask

   function automatic logic [7:0] pat(int i);
      return 8'((i * 7 + 3) % 256);
   endfunction

   task automatic finish_run();
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] req_b [6];
      logic [7:0] got [6];
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state seen through the ports
      phase = "R1 reset state";
      chk("host_rdata", host_rdata, 8'h00);
      chk("req_pending", {7'd0, req_pending}, 8'h00);
      hr(A_PTR, v); chk("pointer", v, 8'h00);
      for (int i = 0; i < 4; i++) begin hr(A_DAT, v); chk("buffer byte", v, 8'h00); end

      // R3: fill buffer from 0
      phase = "R3 data write";
      hw(A_PTR, 8'h00);
      for (int i = 0; i < 64; i++) hw(A_DAT, pat(i));
      hr(A_PTR, v); chk("pointer after 64 writes", v, 8'h00);

      // R10: processor read view
      phase = "R10 proc read";
      for (int i = 0; i < 64; i += 9) begin
         @(posedge clk); #1 proc_addr = 6'(i);
         #0.5 chk("proc_rdata", proc_rdata, pat(i));
      end

      // R4: host reads with wrap
      phase = "R4 data read";
      hw(A_PTR, 8'd60);
      for (int k = 0; k < 6; k++) begin hr(A_DAT, v); chk("read byte", v, pat((60 + k) % 64)); end
      phase = "R2 pointer";
      hr(A_PTR, v); chk("pointer after wrap", v, 8'd2);
      hw(A_PTR, 8'h45); hr(A_PTR, v); chk("pointer mod 64", v, 8'h05);
      hw(A_PTR, 8'hFF); hr(A_PTR, v); chk("pointer mod 64", v, 8'd63);

      // R3: write wrap
      phase = "R3 write wrap";
      hw(A_PTR, 8'd62);
      hw(A_DAT, 8'hA1); hw(A_DAT, 8'hB2); hw(A_DAT, 8'hC3);
      hr(A_PTR, v); chk("pointer", v, 8'd1);
      hw(A_PTR, 8'd62);
      hr(A_DAT, v); chk("byte 62", v, 8'hA1);
      hr(A_DAT, v); chk("byte 63", v, 8'hB2);
      hr(A_DAT, v); chk("byte 0", v, 8'hC3);

      // R5: load-enable gating
      phase = "R5 status load";
      hw(A_STA, 8'h01); chk("no load set", {7'd0, req_pending}, 8'h00);
      hw(A_STA, 8'hFD); chk("no load set", {7'd0, req_pending}, 8'h00);
      hw(A_STA, 8'h03); chk("load set", {7'd0, req_pending}, 8'h01);
      hw(A_STA, 8'h00); chk("no load clear", {7'd0, req_pending}, 8'h01);
      hw(A_STA, 8'h02); chk("stale clear", {7'd0, req_pending}, 8'h00);

      // R6: status read, unmapped read
      phase = "R6 status read";
      hw(A_PTR, 8'd10);
      hr(A_STA, v); chk("status idle", v, 8'h00);
      hw(A_STA, 8'h03);
      hr(A_STA, v); chk("status busy", v, 8'h01);
      hr(A_STA, v); chk("status repeat", v, 8'h01);
      hr(A_PTR, v); chk("pointer unmoved", v, 8'd10);
      hr(8'h10, v); chk("unmapped", v, 8'h00);

      // R7: host data writes ignored while owned
      phase = "R7 owned buffer";
      hw(A_DAT, 8'h5A); hw(A_DAT, 8'h5B);
      hr(A_PTR, v); chk("pointer unmoved", v, 8'd10);
      @(posedge clk); #1 proc_addr = 6'd10;
      #0.5 chk("byte 10 kept", proc_rdata, pat(10));

      // R9: done vs host re-arm in same cycle
      phase = "R9 done priority";
      @(posedge clk); #1 proc_done = 1; host_wr_en = 1; host_addr = A_STA; host_wdata = 8'h03;
      @(posedge clk); #1 proc_done = 0; host_wr_en = 0;
      chk("host re-arm wins", {7'd0, req_pending}, 8'h01);
      @(posedge clk); #1 proc_done = 1;
      @(posedge clk); #1 proc_done = 0;
      chk("done clears", {7'd0, req_pending}, 8'h00);

      // R8: processor writes ignored while host owns
      phase = "R8 proc ownership";
      @(posedge clk); #1 proc_wr_en = 1; proc_addr = 6'd20; proc_wdata = 8'hEE;
      @(posedge clk); #1 proc_wr_en = 0;
      hw(A_PTR, 8'd20); hr(A_DAT, v); chk("byte 20 kept", v, pat(20));

      // R11: full exchange
      phase = "R11 exchange";
      req_b[0] = 8'h3C; req_b[1] = 8'h02;
      req_b[2] = 8'hDE; req_b[3] = 8'hAD; req_b[4] = 8'hBE; req_b[5] = 8'hEF;
      hw(A_PTR, 8'h00);
      for (int k = 0; k < 6; k++) hw(A_DAT, req_b[k]);
      hw(A_STA, 8'h03);
      chk("request raised", {7'd0, req_pending}, 8'h01);
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #1 proc_addr = 6'(k);
         #0.5 got[k] = proc_rdata;
         chk("proc sees request", got[k], req_b[k]);
      end
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #1 proc_wr_en = 1; proc_addr = 6'(k);
         proc_wdata = (k == 0) ? got[0] ^ 8'h80 : (k == 1) ? got[1] : got[k] + 8'h11;
      end
      @(posedge clk); #1 proc_wr_en = 0; proc_done = 1;
      @(posedge clk); #1 proc_done = 0;
      for (int t = 0; t < 20; t++) begin
         hr(A_STA, v);
         if (v[0] == 1'b0) break;
      end
      chk("poll clear", v, 8'h00);
      hw(A_PTR, 8'h00);
      for (int k = 0; k < 6; k++) begin
         hr(A_DAT, v);
         chk("response byte", v,
             (k == 0) ? 8'hBC : (k == 1) ? 8'h02 : req_b[k] + 8'h11);
      end

      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule